// File: doc/BRIEF.md
# PRBS Loopback Self-Test Engine

This block is a built-in self-test for a serial data path. While running, it sends a pseudo-random bit sequence out one bit per clock on `tx_bit`. It checks the bits that come back on `rx_bit` against a copy of the same sequence that it regenerates locally. Because the receive checker finds its own alignment, the loopback path can have any fixed latency, and there is no handshake with the far end.

The control inputs are plain register bits. `run_en` starts and stops the test. `len_sel` chooses between a 9-stage and a 15-stage generator. A one-cycle `inj_wr` strobe stands for software writing 1 to a self-clearing force-error bit. The read side has three outputs:
- the force-error bit as it reads back (`inj_busy`);
- a latched pass flag (`pass_stat`);
- a saturating 8-bit mismatch counter (`err_count`).

Top module: `prbs_selftest`

## Requirements
- R1: In reset, and after reset until the first start, `tx_bit`, `inj_busy`, `pass_stat` and `err_count` are all 0.
- R2: With `len_sel`=0 at start, the stream from the first cycle after the start edge follows b[n] = b[n-9] XOR b[n-5], with b[-1..-9] all 1 (x^9+x^5+1, all-ones seed), so the first bit is 0.
- R3: With `len_sel`=1 at start, the stream follows b[n] = b[n-15] XOR b[n-14], with b[-1..-15] all 1 (x^15+x^14+1, all-ones seed).
- R4: A rising `run_en` starts the test and reseeds the generator. While `run_en` is sampled 0, `tx_bit` stays 0.
- R5: An `inj_wr` strobe in a running cycle inverts exactly the `tx_bit` of the following cycle. `inj_busy` reads 1 in that cycle only and then clears itself.
- R6: An `inj_wr` strobe while the test is stopped is ignored. `inj_busy` stays 0 and no later bit is corrupted.
- R7: The checker locks only after it predicts the returning bits correctly for one sequence length of consecutive cycles, from a nonzero state. Bits before lock are never counted, so loop latency and stale bits cause no errors.
- R8: After lock, each received bit that differs from the regenerated sequence adds exactly one to `err_count`.
- R9: `pass_stat` reads 1 while running and no mismatch has been seen since the start. It drops to 0 on the first mismatch and stays 0 until the test is stopped. While stopped it reads 0, and the fail latch is cleared.
- R10: `err_count` saturates at 255, clears on each start, and holds its value after a stop.
- R11: A change of `len_sel` during a run has no effect until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run_en | input | 1 | Start/stop control bit (1 = run) |
| len_sel | input | 1 | Sequence length select (1 = 15-stage, 0 = 9-stage) |
| inj_wr | input | 1 | One-cycle strobe: write 1 to the force-error bit |
| rx_bit | input | 1 | Returning bit from the loopback path |
| tx_bit | output | 1 | Transmitted sequence bit |
| inj_busy | output | 1 | Force-error bit as read back, self-clearing |
| pass_stat | output | 1 | Latched pass (1) / fail (0) status |
| err_count | output | 8 | Saturating mismatch count |

## Verification
The assertions assume that `rx_bit` returns the transmitted stream through a fixed delay, with single bits corrupted only on purpose. They also assume that `inj_wr` is a single-cycle pulse and is not repeated while a bit is already pending. The bench closes the loop with a fixed four-stage delay line, and it pulses its channel-flip and strobe inputs for one cycle at a time. Errors are corrupted only well after the lock window, so every injected fault maps to exactly one counted mismatch.

// File: rtl/prbs_bist_pkg.sv
package prbs_bist_pkg;

    localparam int unsigned LONG_W    = 15;
    localparam int unsigned LONG_TAP  = 14;
    localparam int unsigned SHORT_W   = 9;
    localparam int unsigned SHORT_TAP = 5;
    localparam int unsigned ERR_W     = 8;
    localparam int unsigned RUN_W     = $clog2(LONG_W + 1);

    typedef enum logic {
        SEQ_SHORT = 1'b0,
        SEQ_LONG  = 1'b1
    } seq_len_e;

    typedef logic [LONG_W-1:0] lfsr_t;
    typedef logic [RUN_W-1:0]  run_t;

    typedef struct packed {
        logic locked;
        logic mismatch;
    } chk_stat_t;

    localparam lfsr_t SHORT_MASK = {{(LONG_W-SHORT_W){1'b0}}, {SHORT_W{1'b1}}};

    // Feedback bit: oldest stage XOR the tap stage of the selected polynomial
    function automatic logic lfsr_fb(lfsr_t s, seq_len_e m);
        if (m == SEQ_LONG)
            return s[LONG_W-1] ^ s[LONG_TAP-1];
        return s[SHORT_W-1] ^ s[SHORT_TAP-1];
    endfunction

    // Shift one bit in at the low end, keeping only the active stages
    function automatic lfsr_t lfsr_step(lfsr_t s, seq_len_e m, logic b);
        lfsr_t n;
        n = {s[LONG_W-2:0], b};
        if (m == SEQ_SHORT)
            n = n & SHORT_MASK;
        return n;
    endfunction

    function automatic lfsr_t seed_of(seq_len_e m);
        return (m == SEQ_LONG) ? '1 : SHORT_MASK;
    endfunction

    function automatic run_t seq_last(seq_len_e m);
        return (m == SEQ_LONG) ? run_t'(LONG_W - 1) : run_t'(SHORT_W - 1);
    endfunction

endpackage

// File: rtl/pbt_prbs_gen.sv
module pbt_prbs_gen
    import prbs_bist_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     seed_ld,
    input  logic     active,
    input  seq_len_e mode,
    input  logic     inj,
    output logic     tx_bit
);

    lfsr_t state;
    logic  fb;

    assign fb     = lfsr_fb(state, mode);
    assign tx_bit = active & (fb ^ inj);

    always_ff @(posedge clk) begin
        if (rst)
            state <= '0;
        else if (seed_ld)
            state <= seed_of(mode);
        else if (active)
            state <= lfsr_step(state, mode, fb);
    end

    // A generator that runs must never fall into the all-zero lock-up state
    AST_STATE_NZ: assert property (@(posedge clk) disable iff (rst)
        active |-> (state != '0)); // R2

endmodule

// File: rtl/pbt_prbs_chk.sv
module pbt_prbs_chk
    import prbs_bist_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      clear,
    input  logic      active,
    input  seq_len_e  mode,
    input  logic      rx_bit,
    output chk_stat_t stat
);

    lfsr_t chk;
    run_t  good_run;
    logic  locked;
    logic  pred;

    assign pred          = lfsr_fb(chk, mode);
    assign stat.locked   = locked;
    assign stat.mismatch = active & locked & (rx_bit != pred);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            chk      <= '0;
            good_run <= '0;
            locked   <= 1'b0;
        end else if (active) begin
            if (locked) begin
                // free-run on the local copy so one bad bit counts once
                chk <= lfsr_step(chk, mode, pred);
            end else begin
                chk <= lfsr_step(chk, mode, rx_bit);
                if ((chk != '0) && (rx_bit == pred)) begin
                    if (good_run == seq_last(mode))
                        locked <= 1'b1;
                    good_run <= good_run + 1'b1;
                end else begin
                    good_run <= '0;
                end
            end
        end
    end

    AST_LOCK_HOLD: assert property (@(posedge clk) disable iff (rst)
        (locked && active && !clear) |=> locked); // R7

endmodule

// File: rtl/prbs_selftest.sv
module prbs_selftest
    import prbs_bist_pkg::*;
#(
    parameter int unsigned CNT_W = ERR_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run_en,
    input  logic             len_sel,
    input  logic             inj_wr,
    input  logic             rx_bit,
    output logic             tx_bit,
    output logic             inj_busy,
    output logic             pass_stat,
    output logic [CNT_W-1:0] err_count
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic       run_q;
    logic       start;
    logic       inj_q;
    logic       fail_seen;
    seq_len_e   mode_q;
    seq_len_e   mode_eff;
    chk_stat_t  cst;
    logic [CNT_W-1:0] err_cnt;

    assign start    = run_en & ~run_q;
    assign mode_eff = start ? seq_len_e'(len_sel) : mode_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q     <= 1'b0;
            mode_q    <= SEQ_SHORT;
            inj_q     <= 1'b0;
            fail_seen <= 1'b0;
            err_cnt   <= '0;
        end else begin
            run_q <= run_en;
            if (start)
                mode_q <= seq_len_e'(len_sel);
            inj_q <= run_q & run_en & inj_wr & ~inj_q;
            if (!run_q)
                fail_seen <= 1'b0;
            else if (cst.mismatch)
                fail_seen <= 1'b1;
            if (start)
                err_cnt <= '0;
            else if (cst.mismatch && (err_cnt != CNT_MAX))
                err_cnt <= err_cnt + 1'b1;
        end
    end

    pbt_prbs_gen u_gen (
        .clk     (clk),
        .rst     (rst),
        .seed_ld (start),
        .active  (run_q),
        .mode    (mode_eff),
        .inj     (inj_q),
        .tx_bit  (tx_bit)
    );

    pbt_prbs_chk u_chk (
        .clk     (clk),
        .rst     (rst),
        .clear   (start),
        .active  (run_q),
        .mode    (mode_eff),
        .rx_bit  (rx_bit),
        .stat    (cst)
    );

    assign inj_busy  = inj_q;
    assign pass_stat = run_q & ~fail_seen;
    assign err_count = err_cnt;

    AST_INJ_SINGLE: assert property (@(posedge clk) disable iff (rst)
        inj_busy |=> !inj_busy); // R5

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
        !start |=> (err_count == $past(err_count)) ||
                   (err_count == $past(err_count) + 1'b1)); // R8

    AST_CNT_SAT: assert property (@(posedge clk) disable iff (rst)
        (err_count == CNT_MAX && !start) |=> (err_count == CNT_MAX)); // R10

    AST_PASS_LATCH: assert property (@(posedge clk) disable iff (rst)
        (run_q && !pass_stat) |=> !pass_stat); // R9

    AST_CNT_ZERO_ON_START: assert property (@(posedge clk) disable iff (rst)
        start |=> (err_count == '0)); // R10

endmodule

// File: tb/prbs_selftest_tb.sv
`timescale 1ns/1ps
module prbs_selftest_tb_top;

    localparam int LAT = 4;
    localparam int MAXB = 600;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic run_en = 1'b0;
    logic len_sel = 1'b0;
    logic inj_wr = 1'b0;
    logic chan_flip = 1'b0;
    logic rx_bit;
    logic tx_bit;
    logic inj_busy;
    logic pass_stat;
    logic [7:0] err_count;
    logic [LAT-1:0] pipe = '0;

    int n_chk = 0;
    int n_fail = 0;
    bit hist [0:MAXB+15];

    always #2 clk = ~clk;

    always @(posedge clk) pipe <= {pipe[LAT-2:0], tx_bit};
    assign rx_bit = pipe[LAT-1] ^ chan_flip;

    prbs_selftest dut_i (
        .clk(clk), .rst(rst), .run_en(run_en), .len_sel(len_sel),
        .inj_wr(inj_wr), .rx_bit(rx_bit), .tx_bit(tx_bit),
        .inj_busy(inj_busy), .pass_stat(pass_stat), .err_count(err_count)
    );

    task automatic check(bit ok, string req, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Reference stream from the recurrence; b[n] lives at hist[n+15]
    function automatic void fill_ref(bit long_mode);
        for (int i = 0; i < 15; i++) hist[i] = 1'b1;
        for (int n = 0; n < MAXB; n++) begin
            if (long_mode) hist[n+15] = hist[n] ^ hist[n+1];
            else           hist[n+15] = hist[n+6] ^ hist[n+10];
        end
    endfunction

    function automatic int exp_cnt(int k);
        return (k > 255) ? 255 : k;
    endfunction

    task automatic stop_test();
        run_en = 1'b0;
        @(negedge clk);
        check(pass_stat == 1'b0, "R9", pass_stat, 0);
        check(tx_bit == 1'b0, "R4", tx_bit, 0);
        repeat (LAT + 1) @(negedge clk);
    endtask

    // Run nbits, comparing tx each cycle; optional strobe and mid-run select change
    task automatic run_seq(bit mode, int nbits, int inj_at, bit sel_flip, string req);
        fill_ref(mode);
        len_sel = mode;
        run_en  = 1'b1;
        @(negedge clk);
        for (int n = 0; n < nbits; n++) begin
            bit exp_b;
            exp_b = hist[n+15] ^ (n == inj_at);
            check(tx_bit == exp_b, (n == inj_at) ? "R5" : req, tx_bit, exp_b);
            if (n == inj_at)     check(inj_busy == 1'b1, "R5", inj_busy, 1);
            if (n == inj_at + 1) check(inj_busy == 1'b0, "R5", inj_busy, 0);
            if (sel_flip && n == 1) len_sel = ~mode;
            inj_wr = (n == inj_at - 1);
            @(negedge clk);
        end
        inj_wr = 1'b0;
        repeat (LAT + 2) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        check(tx_bit == 0 && inj_busy == 0 && pass_stat == 0 && err_count == 0,
              "R1", {tx_bit, inj_busy, pass_stat}, 0);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        check(tx_bit == 0 && pass_stat == 0 && err_count == 0, "R1", err_count, 0);

        // R6: strobe while stopped is ignored
        inj_wr = 1'b1;
        @(negedge clk);
        inj_wr = 1'b0;
        check(inj_busy == 1'b0, "R6", inj_busy, 0);
        check(tx_bit == 1'b0, "R6", tx_bit, 0);

        // R2 and R7: clean 9-stage run, no stale strobe effect
        run_seq(1'b0, 120, -1, 1'b0, "R2");
        check(err_count == 0, "R7", err_count, 0);
        check(pass_stat == 1, "R9", pass_stat, 1);
        stop_test();

        // R3: 15-stage run
        run_seq(1'b1, 150, -1, 1'b0, "R3");
        check(err_count == 0, "R7", err_count, 0);
        check(pass_stat == 1, "R9", pass_stat, 1);
        stop_test();

        // R11: select changed mid-run keeps the 9-stage sequence
        run_seq(1'b0, 100, -1, 1'b1, "R11");
        check(err_count == 0, "R11", err_count, 0);
        stop_test();

        // R5 and R8: one strobe, one corrupted bit, one count
        run_seq(1'b1, 120, 70, 1'b0, "R3");
        check(err_count == 1, "R8", err_count, 1);
        check(pass_stat == 0, "R9", pass_stat, 0);
        stop_test();
        check(err_count == 1, "R10", err_count, 1);

        // R4: restart reseeds; R10 count cleared on start
        run_seq(1'b0, 60, -1, 1'b0, "R4");
        check(err_count == 0, "R10", err_count, 0);

        // R10: saturation with a long burst of channel flips
        @(negedge clk);
        chan_flip = 1'b1;
        repeat (300) @(negedge clk);
        chan_flip = 1'b0;
        repeat (4) @(negedge clk);
        check(err_count == 255, "R10", err_count, 255);
        stop_test();
        check(err_count == 255, "R10", err_count, 255);

        // Random rounds: spaced channel flips after lock
        for (int r = 0; r < 8; r++) begin
            int k;
            bit m;
            m = 1'($urandom_range(0, 1));
            k = $urandom_range(0, 20);
            run_seq(m, 80, -1, 1'b0, "R2");
            for (int f = 0; f < k; f++) begin
                chan_flip = 1'b1;
                @(negedge clk);
                chan_flip = 1'b0;
                repeat ($urandom_range(0, 5)) @(negedge clk);
            end
            repeat (4) @(negedge clk);
            check(err_count == 8'(exp_cnt(k)), "R8", err_count, exp_cnt(k));
            check(pass_stat == (k == 0), "R9", pass_stat, (k == 0));
            stop_test();
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule